// File: doc/BRIEF.md
# Bridge Claim and Forward Decoder

This block makes the claim decision for a bus bridge that joins a primary and a secondary PCI segment. For each transaction presented on its inputs (address, command kind, and which side started it) it reports at once whether the bridge forwards the transaction downstream to the secondary side or claims it upstream toward the primary side. Downstream I/O is decoded against a base/limit window with 4 KB granularity. Legacy display ranges in memory and I/O can be added to the downstream decode, and the I/O ranges repeat on every 1 KB alias. An ISA compatibility mode removes the upper three quarters of every 1 KB block from the window. Memory-space and I/O-space enable bits gate every downstream decision.

The block also forwards a secondary-side system error to the primary side when two enable bits allow it. It masks the per-device IDSEL lines during configuration cycles, so that selected devices stay invisible to enumeration software. Software sets the control bits through a small synchronous register port with byte enables. All decisions are combinational from the registered control bits.

Top module: `bridge_claim_decoder`

## Requirements
- R1: After reset every control bit is zero. All four registers read 0, and no memory or I/O transaction is forwarded downstream.
- R2: Register port. A write with `regWrEn` updates only the bytes whose `regByteEn` bit is set. `regRdData` holds the addressed register one cycle after `regRdEn`. Bits that are not implemented read 0. Register 0 (command): bit 0 is I/O enable, bit 1 is memory enable, bit 8 is error-report enable. Register 1 (bridge control): bit 0 is display-range enable, bit 1 is ISA-mode enable, bit 2 is error-forward enable. Register 2 (I/O window): bits 3:0 hold the base and bits 11:8 hold the limit, both compared with address bits 15:12. Register 3 (hide): bits 7:0 are implemented, and bits 15:8 are reserved and read 0.
- R3: An I/O address lies inside the window when bits 63:16 are zero and base ≤ bits 15:12 ≤ limit. If base > limit, the window is empty.
- R4: With ISA mode set, a window address whose bits 9:8 are nonzero (offset 100h–3FFh in its 1 KB block) gets no downstream forward from the window.
- R5: With display-range enable set, I/O addresses whose bits 63:16 are zero and whose bits 9:0 lie in 3B0h–3BBh or 3C0h–3DFh are forwarded downstream, whatever bits 15:10 hold and whatever the window and ISA mode are.
- R6: With display-range enable set, memory addresses 000A0000h–000BFFFFh are forwarded downstream.
- R7: Downstream I/O forwarding requires I/O enable, and downstream memory forwarding requires memory enable.
- R8: A secondary-side (`txnUpstream`=1) memory or I/O transaction is claimed upstream exactly when it would not hit the downstream decode of R3–R6. This holds regardless of the enable bits. So when display-range enable is clear, the display ranges are claimed upstream.
- R9: `priSerr` = `secSerr` AND error-forward enable AND error-report enable.
- R10: During a configuration transaction (`txnKind`=2), `idselOut[n]` is held low when hide bit n is set. Otherwise `idselOut` equals `idselIn`.
- R11: `fwdDown` is only asserted for primary-side transactions and `fwdUp` only for secondary-side ones. Configuration transactions and kind 3 are never forwarded. The kinds are 0 = memory, 1 = I/O, 2 = configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register index |
| regWrData | input | 16 | Write data |
| regByteEn | input | 2 | Byte enables for writes |
| regRdData | output | 16 | Read data, one cycle after the read strobe |
| txnAddr | input | 64 | Transaction address |
| txnKind | input | 2 | 0 memory, 1 I/O, 2 configuration, 3 none |
| txnUpstream | input | 1 | 1 when the transaction starts on the secondary side |
| idselIn | input | 8 | Raw IDSEL lines for devices 0–7 |
| secSerr | input | 1 | System error from the secondary side |
| idselOut | output | 8 | Gated IDSEL lines |
| fwdDown | output | 1 | Forward to the secondary side |
| fwdUp | output | 1 | Claim toward the primary side |
| priSerr | output | 1 | System error to the primary side |

## Verification
The bench builds the block with its defaults: a 64-bit address, 8 hide bits and a 4-bit window field. The full 64-bit width lets the bench place nonzero bits above bit 16 and bit 20, and so confirm that such addresses fall out of every I/O and display decode. The 4-bit window field keeps the whole span of base and limit values small enough for random register writes to produce empty, single-block and full windows. Random transactions are aimed at the display aliases, the ISA offsets and the window edges.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
  localparam int HIDE_W = 8;
  localparam int WIN_W  = 4;
  localparam int DATA_W = 16;
  localparam int NREG   = 4;

  typedef enum logic [1:0] {
    KIND_MEM  = 2'd0,
    KIND_IO   = 2'd1,
    KIND_CFG  = 2'd2,
    KIND_NONE = 2'd3
  } txnKind_t;

  // strobes and levels the control side hands to the datapath
  typedef struct packed {
    logic              ioEn;
    logic              memEn;
    logic              serrEn;
    logic              vgaEn;
    logic              isaEn;
    logic              serrFwd;
    logic [WIN_W-1:0]  ioBase;
    logic [WIN_W-1:0]  ioLimit;
    logic [HIDE_W-1:0] hide;
  } ctrlBits_t;
endpackage

// File: rtl/bcd_ctrl.sv
`timescale 1ns/1ps
module bcd_ctrl
  import bcd_pkg::*;
#(
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W/8-1:0] byteEn,
  output logic [DATA_W-1:0] rdData,
  output ctrlBits_t         ctrl
);
  localparam int BE_W = DATA_W / 8;

  logic [DATA_W-1:0] regFile [NREG];
  logic [DATA_W-1:0] beMask;

  function automatic logic [DATA_W-1:0] implMask(input int idx);
    logic [DATA_W-1:0] m;
    m = '0;
    case (idx)
      0: begin m[0] = 1'b1; m[1] = 1'b1; m[8] = 1'b1; end
      1: m[2:0] = 3'b111;
      2: begin m[WIN_W-1:0] = '1; m[8 +: WIN_W] = '1; end
      default: m[HIDE_W-1:0] = '1;
    endcase
    return m;
  endfunction

  always_comb begin
    for (int b = 0; b < BE_W; b++) beMask[b*8 +: 8] = {8{byteEn[b]}};
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = implMask(gi);
    always_ff @(posedge clk) begin
      if (!rstN) regFile[gi] <= '0;
      else if (wrEn && (regAddr == REG_AW'(gi)))
        regFile[gi] <= (regFile[gi] & ~beMask) | (wrData & beMask & MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= regFile[regAddr];
  end

  always_comb begin
    ctrl.ioEn    = regFile[0][0];
    ctrl.memEn   = regFile[0][1];
    ctrl.serrEn  = regFile[0][8];
    ctrl.vgaEn   = regFile[1][0];
    ctrl.isaEn   = regFile[1][1];
    ctrl.serrFwd = regFile[1][2];
    ctrl.ioBase  = regFile[2][WIN_W-1:0];
    ctrl.ioLimit = regFile[2][8 +: WIN_W];
    ctrl.hide    = regFile[3][HIDE_W-1:0];
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdEn) && $past(regAddr) == REG_AW'(3)) |-> (rdData[DATA_W-1:HIDE_W] == '0)); // R2

  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdEn) && $past(regAddr) == REG_AW'(0)) |-> (rdData[7:2] == '0)); // R2
endmodule

// File: rtl/bcd_datapath.sv
`timescale 1ns/1ps
module bcd_datapath
  import bcd_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlBits_t         ctrl,
  input  logic [ADDR_W-1:0] txnAddr,
  input  txnKind_t          txnKind,
  input  logic              txnUp,
  input  logic [HIDE_W-1:0] idselIn,
  input  logic              secSerr,
  output logic [HIDE_W-1:0] idselOut,
  output logic              fwdDown,
  output logic              fwdUp,
  output logic              priSerr
);
  localparam int IO_SPACE_W = 16;
  localparam int ALIAS_W    = 10;
  localparam int MEM_LOW_W  = 20;
  localparam logic [ALIAS_W-1:0] MONO_LO  = 10'h3B0;
  localparam logic [ALIAS_W-1:0] MONO_HI  = 10'h3BB;
  localparam logic [ALIAS_W-1:0] COLOR_LO = 10'h3C0;
  localparam logic [ALIAS_W-1:0] COLOR_HI = 10'h3DF;
  localparam logic [MEM_LOW_W-1:0] FRAME_LO = 20'hA0000;
  localparam logic [MEM_LOW_W-1:0] FRAME_HI = 20'hBFFFF;

  logic             ioUpperZero, memUpperZero;
  logic [ALIAS_W-1:0] aliasOff;
  logic [WIN_W-1:0] ioBlock;
  logic             inWin, isaBlk, vgaIo, vgaMem, ioHit, memHit;
  logic             isIo, isMem, isCfg;

  assign isIo  = (txnKind == KIND_IO);
  assign isMem = (txnKind == KIND_MEM);
  assign isCfg = (txnKind == KIND_CFG);

  assign ioUpperZero  = (txnAddr[ADDR_W-1:IO_SPACE_W] == '0);
  assign memUpperZero = (txnAddr[ADDR_W-1:MEM_LOW_W] == '0);
  assign aliasOff     = txnAddr[ALIAS_W-1:0];
  assign ioBlock      = txnAddr[IO_SPACE_W-1 -: WIN_W];

  // window decode, 4 KB steps
  assign inWin  = ioUpperZero && (ioBlock >= ctrl.ioBase) && (ioBlock <= ctrl.ioLimit);
  // ISA mode keeps only the bottom 256 bytes of each 1 KB block
  assign isaBlk = ctrl.isaEn && (txnAddr[ALIAS_W-1:8] != '0);
  assign vgaIo  = ioUpperZero &&
                  (((aliasOff >= MONO_LO) && (aliasOff <= MONO_HI)) ||
                   ((aliasOff >= COLOR_LO) && (aliasOff <= COLOR_HI)));
  assign vgaMem = memUpperZero &&
                  (txnAddr[MEM_LOW_W-1:0] >= FRAME_LO) && (txnAddr[MEM_LOW_W-1:0] <= FRAME_HI);

  assign ioHit  = (inWin && !isaBlk) || (ctrl.vgaEn && vgaIo);
  assign memHit = ctrl.vgaEn && vgaMem;

  always_comb begin
    fwdDown = 1'b0;
    fwdUp   = 1'b0;
    if (!txnUp) begin
      fwdDown = (isIo && ioHit && ctrl.ioEn) || (isMem && memHit && ctrl.memEn);
    end else begin
      fwdUp = (isIo && !ioHit) || (isMem && !memHit);
    end
  end

  for (genvar gn = 0; gn < HIDE_W; gn++) begin : g_idsel
    assign idselOut[gn] = idselIn[gn] & ~(isCfg & ctrl.hide[gn]);
  end

  assign priSerr = secSerr & ctrl.serrFwd & ctrl.serrEn;

  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdDown && fwdUp)); // R11
  AST_CFG_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rstN)
    (txnKind == KIND_CFG) |-> (!fwdDown && !fwdUp)); // R11
  AST_IO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (fwdDown && isIo) |-> ctrl.ioEn); // R7
  AST_MEM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (fwdDown && isMem) |-> (ctrl.memEn && ctrl.vgaEn)); // R7
  AST_ISA_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (isIo && !txnUp && ctrl.isaEn && !ctrl.vgaEn && txnAddr[9:8] != 2'b00) |-> !fwdDown); // R4
  AST_SERR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    priSerr |-> (secSerr && ctrl.serrEn && ctrl.serrFwd)); // R9
  AST_HIDDEN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    isCfg |-> ((idselOut & ctrl.hide) == '0)); // R10
endmodule

// File: rtl/bridge_claim_decoder.sv
`timescale 1ns/1ps
module bridge_claim_decoder
  import bcd_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [15:0]       regWrData,
  input  logic [1:0]        regByteEn,
  output logic [15:0]       regRdData,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic [1:0]        txnKind,
  input  logic              txnUpstream,
  input  logic [7:0]        idselIn,
  input  logic              secSerr,
  output logic [7:0]        idselOut,
  output logic              fwdDown,
  output logic              fwdUp,
  output logic              priSerr
);
  ctrlBits_t ctrlBits;

  bcd_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (regWrEn),
    .rdEn    (regRdEn),
    .regAddr (regAddr),
    .wrData  (regWrData),
    .byteEn  (regByteEn),
    .rdData  (regRdData),
    .ctrl    (ctrlBits)
  );

  bcd_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrlBits),
    .txnAddr  (txnAddr),
    .txnKind  (txnKind_t'(txnKind)),
    .txnUp    (txnUpstream),
    .idselIn  (idselIn),
    .secSerr  (secSerr),
    .idselOut (idselOut),
    .fwdDown  (fwdDown),
    .fwdUp    (fwdUp),
    .priSerr  (priSerr)
  );
endmodule

// File: tb/sim_bridge_claim_decoder.sv
`timescale 1ns/1ps
module sim_bridge_claim_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [1:0]  regByteEn = '0;
  logic [15:0] regRdData;
  logic [63:0] txnAddr = '0;
  logic [1:0]  txnKind = 2'd3;
  logic        txnUpstream = 1'b0;
  logic [7:0]  idselIn = '0;
  logic        secSerr = 1'b0;
  logic [7:0]  idselOut;
  logic        fwdDown, fwdUp, priSerr;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow [4];

  always #2.5 clk = ~clk;

  bridge_claim_decoder u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regByteEn(regByteEn), .regRdData(regRdData),
    .txnAddr(txnAddr), .txnKind(txnKind), .txnUpstream(txnUpstream), .idselIn(idselIn),
    .secSerr(secSerr), .idselOut(idselOut), .fwdDown(fwdDown), .fwdUp(fwdUp), .priSerr(priSerr)
  );

  // implemented bits per register, from R2
  function automatic logic [15:0] regMask(input int a);
    case (a)
      0: return 16'h0103;
      1: return 16'h0007;
      2: return 16'h0F0F;
      default: return 16'h00FF;
    endcase
  endfunction

  function automatic logic expIoHit(input logic [63:0] a);
    logic upZ, win, isa, vga;
    logic [9:0] off;
    upZ = (a[63:16] == 0);
    off = a[9:0];
    win = upZ && (a[15:12] >= shadow[2][3:0]) && (a[15:12] <= shadow[2][11:8]);   // R3
    isa = shadow[1][1] && (off >= 10'h100);                                      // R4
    vga = shadow[1][0] && upZ && ((off >= 10'h3B0 && off <= 10'h3BB) ||
                                  (off >= 10'h3C0 && off <= 10'h3DF));           // R5
    return (win && !isa) || vga;
  endfunction

  function automatic logic expMemHit(input logic [63:0] a);
    return shadow[1][0] && (a >= 64'h000A0000) && (a <= 64'h000BFFFF);          // R6
  endfunction

  // packed expectation {idselOut, fwdDown, fwdUp, priSerr}
  function automatic logic [10:0] expOut(input logic [63:0] a, input logic [1:0] k,
                                          input logic up, input logic [7:0] ids, input logic se);
    logic dn, u;
    logic [7:0] io;
    dn = 0; u = 0;
    if (!up) dn = (k == 2'd1 && expIoHit(a) && shadow[0][0]) ||
                  (k == 2'd0 && expMemHit(a) && shadow[0][1]);                   // R7
    else     u  = (k == 2'd1 && !expIoHit(a)) || (k == 2'd0 && !expMemHit(a));   // R8
    io = (k == 2'd2) ? (ids & ~shadow[3][7:0]) : ids;                            // R10
    return {io, dn, u, se & shadow[1][2] & shadow[0][8]};                        // R9
  endfunction

  task automatic regWrite(input int a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] m;
    @(negedge clk);
    regWrEn = 1; regAddr = 2'(a); regWrData = d; regByteEn = be;
    @(negedge clk);
    regWrEn = 0;
    m = {{8{be[1]}}, {8{be[0]}}};
    shadow[a] = (shadow[a] & ~m) | (d & m & regMask(a));
  endtask

  task automatic regRead(input int a, input string tag);
    @(negedge clk);
    regRdEn = 1; regAddr = 2'(a);
    @(negedge clk);
    regRdEn = 0;
    checks++;
    if (regRdData !== shadow[a]) begin
      errors++;
      $display("FAIL %s reg%0d actual=%h expected=%h", tag, a, regRdData, shadow[a]);
    end
  endtask

  task automatic txn(input logic [63:0] a, input logic [1:0] k, input logic up,
                     input logic [7:0] ids, input logic se, input string tag);
    logic [10:0] e, got;
    @(negedge clk);
    txnAddr = a; txnKind = k; txnUpstream = up; idselIn = ids; secSerr = se;
    #1;
    e = expOut(a, k, up, ids, se);
    got = {idselOut, fwdDown, fwdUp, priSerr};
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s addr=%h kind=%0d up=%0d actual=%h expected=%h", tag, a, k, up, got, e);
    end
  endtask

  function automatic logic [63:0] randAddr();
    logic [63:0] r;
    r = {$urandom, $urandom};
    case ($urandom % 6)
      0: return 64'h0009F000 + 64'($urandom % 32'h22000);
      1: return {48'h0, r[15:0]};
      2: return {48'h0, r[15:10], 10'h3A0 + 10'($urandom % 80)};
      3: return {48'h0, r[15:12], 2'b00, r[9:8], r[7:0]};
      4: return {r[63:17], 1'b0, r[15:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state
    for (int i = 0; i < 4; i++) regRead(i, "R1");
    txn(64'hA0000, 2'd0, 0, 8'hFF, 1, "R1");
    txn(64'h03B0, 2'd1, 0, 8'hFF, 1, "R1");

    // R2: reserved bits, byte enables
    regWrite(3, 16'hFFA5, 2'b11); regRead(3, "R2");
    regWrite(3, 16'h00FF, 2'b10); regRead(3, "R2");
    regWrite(0, 16'hFFFF, 2'b01); regRead(0, "R2");

    // display ranges, window empty (base F, limit 0)
    regWrite(2, 16'h000F, 2'b11);
    regWrite(0, 16'h0103, 2'b11);
    regWrite(1, 16'h0001, 2'b11);
    txn(64'hA0000, 2'd0, 0, 0, 0, "R6");
    txn(64'hBFFFF, 2'd0, 0, 0, 0, "R6");
    txn(64'hC0000, 2'd0, 0, 0, 0, "R6");
    txn(64'h9FFFF, 2'd0, 0, 0, 0, "R6");
    txn(64'h3BB, 2'd1, 0, 0, 0, "R5");
    txn(64'h3BC, 2'd1, 0, 0, 0, "R5");
    txn(64'h3DF, 2'd1, 0, 0, 0, "R5");
    txn(64'h3E0, 2'd1, 0, 0, 0, "R5");
    txn(64'hFC3C0, 2'd1, 0, 0, 0, "R5");
    txn(64'hC3B0, 2'd1, 0, 0, 0, "R5");
    txn(64'h1_0000_03B0, 2'd1, 0, 0, 0, "R5");
    // R8 with display enable set
    txn(64'hA0000, 2'd0, 1, 0, 0, "R8");
    txn(64'h3C4, 2'd1, 1, 0, 0, "R8");
    // R7
    regWrite(0, 16'h0002, 2'b11);
    txn(64'h3B0, 2'd1, 0, 0, 0, "R7");
    regWrite(0, 16'h0001, 2'b11);
    txn(64'hA0000, 2'd0, 0, 0, 0, "R7");
    // R3 window
    regWrite(0, 16'h0103, 2'b11);
    regWrite(1, 16'h0000, 2'b11);
    regWrite(2, 16'h0302, 2'b11);
    txn(64'h2000, 2'd1, 0, 0, 0, "R3");
    txn(64'h3FFF, 2'd1, 0, 0, 0, "R3");
    txn(64'h4000, 2'd1, 0, 0, 0, "R3");
    txn(64'h1FFF, 2'd1, 0, 0, 0, "R3");
    txn(64'h1_0000_2000, 2'd1, 0, 0, 0, "R3");
    // R8 with display enable clear
    txn(64'hA0000, 2'd0, 1, 0, 0, "R8");
    txn(64'h2000, 2'd1, 1, 0, 0, "R8");
    txn(64'h5000, 2'd1, 1, 0, 0, "R8");
    // R4 ISA mode
    regWrite(1, 16'h0002, 2'b11);
    txn(64'h20FF, 2'd1, 0, 0, 0, "R4");
    txn(64'h2100, 2'd1, 0, 0, 0, "R4");
    txn(64'h23FF, 2'd1, 0, 0, 0, "R4");
    txn(64'h2400, 2'd1, 0, 0, 0, "R4");
    txn(64'h2100, 2'd1, 1, 0, 0, "R8");
    regWrite(1, 16'h0003, 2'b11);
    txn(64'h23B0, 2'd1, 0, 0, 0, "R5");
    // R11
    txn(64'h2000, 2'd2, 0, 8'hFF, 0, "R11");
    txn(64'h2000, 2'd3, 1, 8'hFF, 0, "R11");
    // R9 truth table
    for (int c = 0; c < 8; c++) begin
      regWrite(0, {7'b0, c[0], 8'h03}, 2'b11);
      regWrite(1, {13'b0, c[1], 2'b11}, 2'b11);
      txn(64'h0, 2'd3, 0, 0, c[2], "R9");
    end
    // R10
    regWrite(3, 16'h005A, 2'b11);
    txn(64'h0, 2'd2, 0, 8'hFF, 0, "R10");
    txn(64'h0, 2'd0, 0, 8'hFF, 0, "R10");
    txn(64'h0, 2'd2, 0, 8'h81, 0, "R10");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 8) == 0) begin
        int ra;
        ra = int'($urandom % 4);
        regWrite(ra, 16'($urandom), 2'($urandom));
        if (($urandom % 4) == 0) regRead(ra, "R2");
      end else begin
        txn(randAddr(), 2'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), "R3-R11 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule